// File: doc/BRIEF.md
# Byte-Wide SPI Master Controller

This block is a serial peripheral interface master that exchanges exactly one byte per software request. It has no FIFO: software loads a transmit byte into a small byte-addressed register file, then sets a start bit. The controller shifts eight bits out on `mosi` while capturing eight bits from `miso`, and drives `sck` from a programmable divider of the bus clock. When the byte completes, the captured byte is latched, a receive-ready flag is set and `irq` is raised. Software then reads the received byte, which clears the flag and the interrupt, and starts the next byte.

A mode register selects the SCK idle level, the edge on which data is captured, the bit order and port enable. A loopback mode feeds the outgoing serial stream straight back into the receive shifter. The busy flag is still set for one bus clock after the receive-ready flag rises. Software that sees the interrupt may therefore still read busy as set.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `sck` is 0.
- R2: Registers sit at byte offsets 0 mode (5 bits, upper bits read 0), 1 receive data (read only), 2 transmit data, 3 control (write only, reads 0), 4 status, 5 reserved (reads 0) and 6 clock divisor. Written values read back unchanged.
- R3: Writing 1 to control bit 0 starts an 8-bit exchange of the transmit register's value, but only when mode bit 0x08 (enable) is 1 and the port is idle. Otherwise the write is ignored. The byte in flight is unaffected by later writes to the transmit register.
- R4: While idle, `sck` equals mode bit 0x02 (1 = idle high). During a transfer the SCK period is 4 × (divisor + 1) bus clocks.
- R5: Mode bit 0x10 = 1 captures data on the leading SCK edge and changes it on the trailing edge. Mode bit 0x10 = 0 changes data on the leading edge and captures on the trailing edge.
- R6: Mode bit 0x04 = 0 shifts the most significant bit first. Mode bit 0x04 = 1 shifts the least significant bit first, in both directions.
- R7: With mode bit 0x01 (loopback) set, `miso` is ignored and the received byte equals the transmitted byte.
- R8: On completion the received byte is latched, status bit 0x01 (ready) is set and `irq` rises. In that first cycle status bit 0x02 (busy) still reads 1; it reads 0 one cycle later.
- R9: Reading offset 1 clears the ready flag and `irq`. The receive register keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (has side effects on offset 1) |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Receive-ready interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest conditions to reach are the second start request that arrives mid-byte and the one-cycle window in which ready and busy are both set. The bench reaches the first with a transfer that, partway through, rewrites the transmit register and strobes start again. It then expects a single completion carrying the original byte. It catches the second by reading status at the first falling clock edge after `irq` rises and again one cycle later. A bench-side slave tracks the actual SCK transitions, so each of the four clock modes, both bit orders and loopback are checked against bit-level capture on both sides, not only against the register contents.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] OFS_MODE = 3'd0;
    localparam logic [REG_AW-1:0] OFS_RXD  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_TXD  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd3;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd4;
    localparam logic [REG_AW-1:0] OFS_DIV  = 3'd6;

    // Field order fixes the bit weights: lead_cap=0x10 ... loopback=0x01
    typedef struct packed {
        logic lead_cap;
        logic enable;
        logic lsb_first;
        logic idle_hi;
        logic loopback;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LINGER
    } eng_state_t;

endpackage

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // one SCK half period lasts 2*(div+1) bus clocks
    assign limit = {div, 1'b1};
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_byte_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  mode_t         cfg_in,
    input  logic [DW-1:0] tx_byte,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          shifting,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          sck,
    output logic          mosi
);
    localparam int EW = $clog2(2 * DW);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

    eng_state_t    state_q;
    logic          lead_q, lsb_q, hi_q, loop_q;
    logic [DW-1:0] tx_sh, rx_sh;
    logic [EW-1:0] edge_q;
    logic          sck_q;

    logic          leading, capture, launch, in_bit, accept;
    logic [DW-1:0] tx_ord, rx_next, rx_ord;

    assign accept  = start && cfg_in.enable && (state_q == ST_IDLE);
    assign leading = ~edge_q[0];
    assign capture = lead_q ? leading : ~leading;
    assign launch  = ~capture;
    assign in_bit  = loop_q ? tx_sh[DW-1] : miso;
    assign rx_next = capture ? {rx_sh[DW-2:0], in_bit} : rx_sh;

    generate
        for (genvar i = 0; i < DW; i++) begin : g_order
            assign tx_ord[i] = cfg_in.lsb_first ? tx_byte[DW-1-i] : tx_byte[i];
            assign rx_ord[i] = lsb_q ? rx_next[DW-1-i] : rx_next[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lead_q  <= 1'b0;
            lsb_q   <= 1'b0;
            hi_q    <= 1'b0;
            loop_q  <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            edge_q  <= '0;
            sck_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_SHIFT;
                        lead_q  <= cfg_in.lead_cap;
                        lsb_q   <= cfg_in.lsb_first;
                        hi_q    <= cfg_in.idle_hi;
                        loop_q  <= cfg_in.loopback;
                        tx_sh   <= tx_ord;
                        rx_sh   <= '0;
                        edge_q  <= '0;
                        sck_q   <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sck_q  <= ~sck_q;
                        rx_sh  <= rx_next;
                        edge_q <= edge_q + 1'b1;
                        // first leading edge never launches: bit 0 is already out
                        if (launch && !(leading && edge_q == '0)) begin
                            tx_sh <= {tx_sh[DW-2:0], 1'b0};
                        end
                        if (edge_q == LAST_EDGE) begin
                            state_q <= ST_LINGER;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign shifting = (state_q == ST_SHIFT);
    assign done     = shifting && tick && (edge_q == LAST_EDGE);
    assign rx_byte  = rx_ord;
    assign sck      = ((state_q == ST_IDLE) ? cfg_in.idle_hi : hi_q) ^ sck_q;
    assign mosi     = tx_sh[DW-1];
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    mode_t             mode_q;
    logic [REG_DW-1:0] tx_q, rx_q;
    logic [DIV_W-1:0]  div_q;
    logic              rdy_q;

    logic              start_req, busy_w, shifting_w, done_w, tick_w;
    logic [REG_DW-1:0] rx_w;

    assign start_req = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];

    spi_sck_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (shifting_w),
        .div  (div_q),
        .tick (tick_w)
    );

    spi_shift_engine #(.DW(REG_DW)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start_req),
        .cfg_in   (mode_q),
        .tx_byte  (tx_q),
        .tick     (tick_w),
        .miso     (miso),
        .busy     (busy_w),
        .shifting (shifting_w),
        .done     (done_w),
        .rx_byte  (rx_w),
        .sck      (sck),
        .mosi     (mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            tx_q   <= '0;
            div_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_MODE: mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
                OFS_TXD:  tx_q   <= reg_wdata;
                OFS_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q  <= '0;
            rdy_q <= 1'b0;
        end else if (done_w) begin
            rx_q  <= rx_w;
            rdy_q <= 1'b1;
        end else if (reg_rd && reg_addr == OFS_RXD) begin
            rdy_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE: reg_rdata = REG_DW'(mode_q);
            OFS_RXD:  reg_rdata = rx_q;
            OFS_TXD:  reg_rdata = tx_q;
            OFS_STAT: reg_rdata = {{(REG_DW-2){1'b0}}, busy_w, rdy_q};
            OFS_DIV:  reg_rdata = REG_DW'(div_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = rdy_q;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
    import spi_byte_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_rd,
    input logic              start_req,
    input mode_t             mode_q,
    input logic              busy,
    input logic              done,
    input logic              irq,
    input logic              sck
);
    assert_idle_sck_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == mode_q.idle_hi));

    assert_start_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (start_req && !mode_q.enable && !busy) |=> !busy);

    assert_busy_linger_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (busy && irq));

    assert_busy_drops_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ##2 !busy);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_RXD && !done) |=> !irq);
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .start_req (start_req),
    .mode_q    (mode_q),
    .busy      (busy_w),
    .done      (done_w),
    .irq       (irq),
    .sck       (sck)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq, sck, mosi;
    logic       miso = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_byte_master u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    // ---------------- bench slave ----------------
    bit         b_cpol, b_lead, b_lsb;
    bit         xfer_on = 1'b0;
    bit         first_lead, s_is_lead;
    logic [7:0] s_sh, s_rx;
    int         lead_n, t_first, t_last;

    always @(sck) begin
        if (xfer_on) begin
            s_is_lead = (sck != b_cpol);
            if (s_is_lead) begin
                if (lead_n == 0) t_first = cyc;
                if (lead_n == 7) t_last = cyc;
                lead_n++;
            end
            if (s_is_lead == b_lead) begin
                s_rx = {s_rx[6:0], mosi};
            end else if (!(s_is_lead && first_lead)) begin
                s_sh = {s_sh[6:0], 1'b0};
                miso = s_sh[7];
            end
            if (s_is_lead) first_lead = 1'b0;
        end
    end

    // ---------------- scoreboard monitor ----------------
    logic [7:0] exp_mosi_q[$];

    initial begin
        forever begin
            @(posedge irq);
            @(negedge clk);
            if (exp_mosi_q.size() == 0) begin
                chk(1'b0, "R3 unexpected completion", 1, 0);
            end else begin
                logic [7:0] e, got;
                e   = exp_mosi_q.pop_front();
                got = b_lsb ? rev8(s_rx) : s_rx;
                chk(got == e, "R5/R6 slave-captured byte", got, e);
            end
        end
    end

    // ---------------- bus driver ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] mode, input logic [7:0] dv,
                        input logic [7:0] tx, input logic [7:0] sb,
                        input bit poke, input string tag);
        logic [7:0] d, exp_rx;
        bit got;
        b_cpol = mode[1]; b_lead = mode[4]; b_lsb = mode[2];
        wr(3'd0, mode);
        wr(3'd6, dv);
        wr(3'd2, tx);
        chk(sck == b_cpol, {tag, " R4 idle level"}, sck, b_cpol);
        s_sh = b_lsb ? rev8(sb) : sb;
        miso = s_sh[7];
        s_rx = '0; first_lead = 1'b1; lead_n = 0;
        xfer_on = 1'b1;
        exp_mosi_q.push_back(tx);
        wr(3'd3, 8'h01);
        if (poke) begin
            repeat (20) @(negedge clk);
            wr(3'd2, 8'hFF);
            wr(3'd3, 8'h01);
        end
        reg_addr = 3'd4;
        got = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (irq) begin got = 1'b1; break; end
        end
        chk(got, {tag, " R3 completion seen"}, got, 1);
        #1 chk(reg_rdata == 8'h03, {tag, " R8 busy lingers with ready"}, reg_rdata, 8'h03);
        @(negedge clk);
        chk(reg_rdata == 8'h01, {tag, " R8 busy cleared next cycle"}, reg_rdata, 8'h01);
        chk((t_last - t_first) == 28 * (int'(dv) + 1), {tag, " R4 sck period"},
            t_last - t_first, 28 * (int'(dv) + 1));
        exp_rx = mode[0] ? tx : sb;
        rd(3'd1, d);
        chk(d == exp_rx, {tag, " R5/R6/R7 received byte"}, d, exp_rx);
        #1 chk(irq == 1'b0, {tag, " R9 irq cleared by read"}, irq, 0);
        xfer_on = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(sck == 1'b0, "R1 sck after reset", sck, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == 8'h00, "R1 register after reset", d, 0);
        end

        // R2 register map readback
        wr(3'd0, 8'hFF); rd(3'd0, d); chk(d == 8'h1F, "R2 mode readback", d, 8'h1F);
        wr(3'd2, 8'h5C); rd(3'd2, d); chk(d == 8'h5C, "R2 tx readback", d, 8'h5C);
        wr(3'd6, 8'hA7); rd(3'd6, d); chk(d == 8'hA7, "R2 divisor readback", d, 8'hA7);
        wr(3'd5, 8'h33); rd(3'd5, d); chk(d == 8'h00, "R2 reserved reads 0", d, 0);
        wr(3'd0, 8'h00);

        // four clock modes, both bit orders, R4 R5 R6
        xfer(8'h18, 8'd2, 8'hA5, 8'h3C, 1'b0, "mode0");
        xfer(8'h08, 8'd0, 8'h96, 8'h5A, 1'b0, "mode1");
        xfer(8'h1A, 8'd1, 8'hC3, 8'h81, 1'b0, "mode2");
        xfer(8'h0E, 8'd0, 8'h01, 8'h80, 1'b0, "mode3 lsb");
        xfer(8'h1C, 8'd3, 8'h12, 8'h48, 1'b0, "mode0 lsb");

        // R7 loopback ignores miso
        xfer(8'h19, 8'd0, 8'h7E, 8'h00, 1'b0, "loopback");

        // R9 receive register holds after read
        rd(3'd1, d); chk(d == 8'h7E, "R9 rx held after read", d, 8'h7E);
        rd(3'd4, d); chk(d == 8'h00, "R9 ready stays clear", d, 0);

        // R3 start ignored while disabled
        wr(3'd0, 8'h10);
        wr(3'd2, 8'hE1);
        wr(3'd3, 8'h01);
        repeat (10) @(negedge clk);
        rd(3'd4, d); chk(d == 8'h00, "R3 disabled start ignored", d, 0);
        chk(irq == 1'b0, "R3 no irq when disabled", irq, 0);
        rd(3'd1, d); chk(d == 8'h7E, "R3 rx untouched when disabled", d, 8'h7E);

        // R3 start while busy ignored; byte in flight unaffected
        xfer(8'h18, 8'd1, 8'h6B, 8'hD2, 1'b1, "restart");
        rd(3'd2, d); chk(d == 8'hFF, "R2 tx write while busy lands", d, 8'hFF);
        repeat (100) @(negedge clk);
        chk(irq == 1'b0, "R3 no second completion", irq, 0);
        chk(exp_mosi_q.size() == 0, "R3 scoreboard drained", exp_mosi_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule